// File: doc/BRIEF.md
# Platform System Control Register File

This block is a byte-wide register file that sits on a simple I/O strobe bus and gives the platform its control and identification registers. A host reads and writes single bytes through `addr_i`, `wdata_i`, `wr_i` and `rd_i`. Read data comes back one cycle after the read strobe, with a one-cycle `rvalid_o`.

The block holds a few control latches. These are the byte-order mode, a disk-activity lamp, a 4-bit system control field and the I/O address map type. Each latch drives an output pin so the surrounding logic can use it. The block also answers a set of identification and equipment addresses with constant codes, and it keeps two scratch bytes. Certain writes are not stored. Instead they emit single-cycle pulses: a soft-reset request to the reset controller and lock toggles to an external NVRAM lock controller. Any access to an address the block does not decode reads as 0xFF, changes nothing, and pulses a decode-error flag.

Top module: `plat_sysctl_regs`

## Requirements
- R1: While reset is asserted and right after it is released, every latch, every scratch byte and every output is 0.
- R2: A write to 0x0092 sets `little_endian_o` to data bit 1. If data bit 0 is 1, the write also raises `soft_reset_o` for exactly one cycle. A read of 0x0092 returns 0x00.
- R3: Reads of the fixed codes return: 0x0800 gives 0xEF, 0x0802 gives 0xAD, 0x0803 gives 0xE0, 0x080C gives 0x3C, 0x0810 gives 0x39, 0x0818 gives 0x00, and 0x0823 gives 0x03.
- R4: Writes to 0x0800, 0x0802 and 0x0803 are accepted without error, but they leave the read values of those addresses unchanged.
- R5: A write to 0x0808 sets `disk_light_o` to data bit 0.
- R6: A write to 0x0810 pulses `nvram_lock_toggle_o[0]` for one cycle, and a write to 0x0812 pulses `nvram_lock_toggle_o[1]` for one cycle. At most one bit is high at a time.
- R7: A write to 0x081C stores data bits 3:0 on `sys_ctrl_o`. A read of 0x081C returns that field zero-extended to 8 bits.
- R8: A write to 0x0850 stores data bit 0 on `io_map_o`, where 1 means non-contiguous. A read of 0x0850 returns that bit zero-extended.
- R9: Some addresses are unlisted. For reads, the listed set is 0x0092, 0x0398, 0x0399, 0x0800, 0x0802, 0x0803, 0x080C, 0x0810, 0x0814, 0x0818, 0x081C, 0x0823 and 0x0850. For writes, the listed set is 0x0092, 0x0398, 0x0399, 0x0800, 0x0802, 0x0803, 0x0808, 0x0810, 0x0812, 0x0814, 0x081C and 0x0850. A read of an unlisted address returns 0xFF. A write to an unlisted address changes no state. In both cases `decode_err_o` is high for the one cycle after the access. A read of 0x0814 returns 0xFF without error.
- R10: Addresses 0x0398 and 0x0399 are two independent read/write scratch bytes.
- R11: `rdata_o` and `rvalid_o` update on the clock edge that samples `rd_i`. `rvalid_o` is high for one cycle per read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Byte address of the access |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe, one access per cycle |
| rdata_o | output | 8 | Read data, registered |
| rvalid_o | output | 1 | Read data valid pulse |
| little_endian_o | output | 1 | Byte-order mode latch |
| disk_light_o | output | 1 | Disk-activity lamp latch |
| sys_ctrl_o | output | 4 | System control field |
| io_map_o | output | 1 | I/O map type, 1 = non-contiguous |
| soft_reset_o | output | 1 | Soft-reset request pulse |
| nvram_lock_toggle_o | output | 2 | NVRAM lock toggle pulses, bit 0 = lock A, bit 1 = lock B |
| decode_err_o | output | 1 | Unlisted-access pulse |

## Verification
The bench sweeps every fixed-code address and then rewrites the read-only ones. This separates decode errors from writes that are wrongly stored. The latches are driven with data that has extra bits set beyond the stored field, for example 0xA5 to the control field and 0xFE to the lamp. This exposes masking mistakes. Pulse outputs are sampled on the cycle after the write and on the cycle after that, which separates a pulse from a level. Unlisted reads and writes go next to the listed ones, for example a read of the lamp address and writes to the code addresses. This shows that the decode is asymmetric between reads and writes, and that unlisted accesses leave stored state untouched.

// File: rtl/plat_sysctl_pkg.sv
package plat_sysctl_pkg;

  localparam int unsigned DATA_W    = 8;
  localparam int unsigned SYSCTL_W  = 4;
  localparam int unsigned SCRATCH_N = 2;

  localparam logic [15:0] A_RSTCTL    = 16'h0092;
  localparam logic [15:0] A_SCRATCH   = 16'h0398;
  localparam logic [15:0] A_CPU_ID    = 16'h0800;
  localparam logic [15:0] A_FEATURE   = 16'h0802;
  localparam logic [15:0] A_STATUS    = 16'h0803;
  localparam logic [15:0] A_LIGHT     = 16'h0808;
  localparam logic [15:0] A_EQUIP     = 16'h080C;
  localparam logic [15:0] A_LOCK_A    = 16'h0810;
  localparam logic [15:0] A_LOCK_B    = 16'h0812;
  localparam logic [15:0] A_CACHE_INV = 16'h0814;
  localparam logic [15:0] A_KEYLOCK   = 16'h0818;
  localparam logic [15:0] A_SYSCTL    = 16'h081C;
  localparam logic [15:0] A_L2_INFO   = 16'h0823;
  localparam logic [15:0] A_MAPTYPE   = 16'h0850;

  localparam logic [7:0] V_CPU_ID  = 8'hEF;
  localparam logic [7:0] V_FEATURE = 8'hAD;
  localparam logic [7:0] V_STATUS  = 8'hE0;
  localparam logic [7:0] V_EQUIP   = 8'h3C;
  localparam logic [7:0] V_EXTFEAT = 8'h39;
  localparam logic [7:0] V_KEYLOCK = 8'h00;
  localparam logic [7:0] V_L2_INFO = 8'h03;
  localparam logic [7:0] V_UNMAP   = 8'hFF;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RSTCTL, SEL_SCRATCH, SEL_CPU_ID, SEL_FEATURE, SEL_STATUS,
    SEL_LIGHT, SEL_EQUIP, SEL_LOCK_A, SEL_LOCK_B, SEL_CACHE_INV, SEL_KEYLOCK,
    SEL_SYSCTL, SEL_L2_INFO, SEL_MAPTYPE
  } reg_sel_e;

  function automatic logic rd_ok(reg_sel_e s);
    case (s)
      SEL_NONE, SEL_LIGHT, SEL_LOCK_B: rd_ok = 1'b0;
      default:                         rd_ok = 1'b1;
    endcase
  endfunction

  function automatic logic wr_ok(reg_sel_e s);
    case (s)
      SEL_NONE, SEL_EQUIP, SEL_KEYLOCK, SEL_L2_INFO: wr_ok = 1'b0;
      default:                                       wr_ok = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/plat_sysctl_decode.sv
module plat_sysctl_decode
  import plat_sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SCR_N  = SCRATCH_N,
  localparam int unsigned IDX_W = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [IDX_W-1:0]  scr_idx_o
);

  logic [SCR_N-1:0] scr_hit;

  for (genvar g = 0; g < SCR_N; g++) begin : g_scr
    assign scr_hit[g] = (addr_i == ADDR_W'(A_SCRATCH + 16'(g)));
  end

  always_comb begin
    scr_idx_o = '0;
    for (int i = 0; i < int'(SCR_N); i++) begin
      if (scr_hit[i]) scr_idx_o = IDX_W'(i);
    end
  end

  always_comb begin
    sel_o = SEL_NONE;
    if (|scr_hit)                                sel_o = SEL_SCRATCH;
    else if (addr_i == ADDR_W'(A_RSTCTL))        sel_o = SEL_RSTCTL;
    else if (addr_i == ADDR_W'(A_CPU_ID))        sel_o = SEL_CPU_ID;
    else if (addr_i == ADDR_W'(A_FEATURE))       sel_o = SEL_FEATURE;
    else if (addr_i == ADDR_W'(A_STATUS))        sel_o = SEL_STATUS;
    else if (addr_i == ADDR_W'(A_LIGHT))         sel_o = SEL_LIGHT;
    else if (addr_i == ADDR_W'(A_EQUIP))         sel_o = SEL_EQUIP;
    else if (addr_i == ADDR_W'(A_LOCK_A))        sel_o = SEL_LOCK_A;
    else if (addr_i == ADDR_W'(A_LOCK_B))        sel_o = SEL_LOCK_B;
    else if (addr_i == ADDR_W'(A_CACHE_INV))     sel_o = SEL_CACHE_INV;
    else if (addr_i == ADDR_W'(A_KEYLOCK))       sel_o = SEL_KEYLOCK;
    else if (addr_i == ADDR_W'(A_SYSCTL))        sel_o = SEL_SYSCTL;
    else if (addr_i == ADDR_W'(A_L2_INFO))       sel_o = SEL_L2_INFO;
    else if (addr_i == ADDR_W'(A_MAPTYPE))       sel_o = SEL_MAPTYPE;
  end

endmodule

// File: rtl/plat_sysctl_ctrl.sv
module plat_sysctl_ctrl
  import plat_sysctl_pkg::*;
#(
  parameter int unsigned SCR_N  = SCRATCH_N,
  localparam int unsigned IDX_W = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  reg_sel_e                sel_i,
  input  logic [IDX_W-1:0]        scr_idx_i,
  output logic                    le_o,
  output logic                    light_o,
  output logic [SYSCTL_W-1:0]     sysctl_o,
  output logic                    map_o,
  output logic [SCR_N*DATA_W-1:0] scratch_o,
  output logic                    soft_reset_o,
  output logic [1:0]              lock_o,
  output logic                    wr_err_o
);

  logic wen;
  assign wen = wr_i && wr_ok(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      le_o     <= 1'b0;
      light_o  <= 1'b0;
      sysctl_o <= '0;
      map_o    <= 1'b0;
    end else if (wen) begin
      case (sel_i)
        SEL_RSTCTL:  le_o     <= wdata_i[1];
        SEL_LIGHT:   light_o  <= wdata_i[0];
        SEL_SYSCTL:  sysctl_o <= wdata_i[SYSCTL_W-1:0];
        SEL_MAPTYPE: map_o    <= wdata_i[0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < SCR_N; g++) begin : g_scr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) scratch_o[g*DATA_W +: DATA_W] <= '0;
      else if (wen && sel_i == SEL_SCRATCH && scr_idx_i == IDX_W'(g))
        scratch_o[g*DATA_W +: DATA_W] <= wdata_i;
    end
  end

  // side-effect pulses, one cycle each
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      soft_reset_o <= 1'b0;
      lock_o       <= '0;
      wr_err_o     <= 1'b0;
    end else begin
      soft_reset_o <= wen && sel_i == SEL_RSTCTL && wdata_i[0];
      lock_o[0]    <= wen && sel_i == SEL_LOCK_A;
      lock_o[1]    <= wen && sel_i == SEL_LOCK_B;
      wr_err_o     <= wr_i && !wr_ok(sel_i);
    end
  end

endmodule

// File: rtl/plat_sysctl_rdmux.sv
module plat_sysctl_rdmux
  import plat_sysctl_pkg::*;
#(
  parameter int unsigned SCR_N  = SCRATCH_N,
  localparam int unsigned IDX_W = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rd_i,
  input  reg_sel_e                sel_i,
  input  logic [IDX_W-1:0]        scr_idx_i,
  input  logic [SYSCTL_W-1:0]     sysctl_i,
  input  logic                    map_i,
  input  logic [SCR_N*DATA_W-1:0] scratch_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    rvalid_o,
  output logic                    rd_err_o
);

  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    case (sel_i)
      SEL_RSTCTL:  rd_nxt = '0;
      SEL_SCRATCH: rd_nxt = scratch_i[scr_idx_i*DATA_W +: DATA_W];
      SEL_CPU_ID:  rd_nxt = V_CPU_ID;
      SEL_FEATURE: rd_nxt = V_FEATURE;
      SEL_STATUS:  rd_nxt = V_STATUS;
      SEL_EQUIP:   rd_nxt = V_EQUIP;
      SEL_LOCK_A:  rd_nxt = V_EXTFEAT;
      SEL_KEYLOCK: rd_nxt = V_KEYLOCK;
      SEL_SYSCTL:  rd_nxt = DATA_W'(sysctl_i);
      SEL_L2_INFO: rd_nxt = V_L2_INFO;
      SEL_MAPTYPE: rd_nxt = DATA_W'(map_i);
      default:     rd_nxt = V_UNMAP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      rd_err_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      rd_err_o <= rd_i && !rd_ok(sel_i);
      if (rd_i) rdata_o <= rd_nxt;
    end
  end

endmodule

// File: rtl/plat_sysctl_regs.sv
module plat_sysctl_regs
  import plat_sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                wr_i,
  input  logic                rd_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                rvalid_o,
  output logic                little_endian_o,
  output logic                disk_light_o,
  output logic [SYSCTL_W-1:0] sys_ctrl_o,
  output logic                io_map_o,
  output logic                soft_reset_o,
  output logic [1:0]          nvram_lock_toggle_o,
  output logic                decode_err_o
);

  localparam int unsigned IDX_W = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1;

  reg_sel_e                    sel;
  logic [IDX_W-1:0]            scr_idx;
  logic [SCRATCH_N*DATA_W-1:0] scratch;
  logic                        wr_err, rd_err;

  plat_sysctl_decode #(.ADDR_W(ADDR_W), .SCR_N(SCRATCH_N)) u_decode (
    .addr_i    (addr_i),
    .sel_o     (sel),
    .scr_idx_o (scr_idx)
  );

  plat_sysctl_ctrl #(.SCR_N(SCRATCH_N)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_i),
    .wdata_i      (wdata_i),
    .sel_i        (sel),
    .scr_idx_i    (scr_idx),
    .le_o         (little_endian_o),
    .light_o      (disk_light_o),
    .sysctl_o     (sys_ctrl_o),
    .map_o        (io_map_o),
    .scratch_o    (scratch),
    .soft_reset_o (soft_reset_o),
    .lock_o       (nvram_lock_toggle_o),
    .wr_err_o     (wr_err)
  );

  plat_sysctl_rdmux #(.SCR_N(SCRATCH_N)) u_rdmux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (rd_i),
    .sel_i     (sel),
    .scr_idx_i (scr_idx),
    .sysctl_i  (sys_ctrl_o),
    .map_i     (io_map_o),
    .scratch_i (scratch),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o),
    .rd_err_o  (rd_err)
  );

  assign decode_err_o = wr_err | rd_err;

endmodule

// File: rtl/plat_sysctl_regs_chk.sv
module plat_sysctl_regs_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [7:0]        rdata_o,
  input logic              rvalid_o,
  input logic              little_endian_o,
  input logic [3:0]        sys_ctrl_o,
  input logic              soft_reset_o,
  input logic [1:0]        nvram_lock_toggle_o
);

  AST_SOFTRST_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_reset_o |-> $past(wr_i && addr_i == ADDR_W'(16'h0092) && wdata_i[0])); // R2

  AST_ENDIAN_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(16'h0092)) |=> little_endian_o == $past(wdata_i[1])); // R2

  AST_LOCK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(nvram_lock_toggle_o)); // R6

  AST_LOCK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nvram_lock_toggle_o[0] |=> !nvram_lock_toggle_o[0] || $past(wr_i)); // R6

  AST_SYSCTL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == ADDR_W'(16'h081C)) |=> $stable(sys_ctrl_o)); // R7

  AST_UNMAP_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(16'h0808)) |=> rdata_o == 8'hFF); // R9

  AST_RVALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o); // R11

endmodule

bind plat_sysctl_regs plat_sysctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i               (clk_i),
  .rst_ni              (rst_ni),
  .addr_i              (addr_i),
  .wdata_i             (wdata_i),
  .wr_i                (wr_i),
  .rd_i                (rd_i),
  .rdata_o             (rdata_o),
  .rvalid_o            (rvalid_o),
  .little_endian_o     (little_endian_o),
  .sys_ctrl_o          (sys_ctrl_o),
  .soft_reset_o        (soft_reset_o),
  .nvram_lock_toggle_o (nvram_lock_toggle_o)
);

// File: tb/plat_sysctl_regs_bench.sv
module plat_sysctl_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata;
  logic        rvalid, le, light, map, srst, derr;
  logic [3:0]  sctl;
  logic [1:0]  lock;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [15:0] a;
    logic [7:0]  exp;
    string       tag;
  } rd_item_t;
  rd_item_t exp_q[$];

  always #4 clk = ~clk;

  plat_sysctl_regs u_plat_sysctl_regs (
    .clk_i               (clk),
    .rst_ni              (rst_n),
    .addr_i              (addr),
    .wdata_i             (wdata),
    .wr_i                (wr),
    .rd_i                (rd),
    .rdata_o             (rdata),
    .rvalid_o            (rvalid),
    .little_endian_o     (le),
    .disk_light_o        (light),
    .sys_ctrl_o          (sctl),
    .io_map_o            (map),
    .soft_reset_o        (srst),
    .nvram_lock_toggle_o (lock),
    .decode_err_o        (derr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected rvalid", 1, 0);
      else begin
        rd_item_t it;
        it = exp_q.pop_front();
        chk(rdata == it.exp, it.tag, rdata, it.exp);
      end
    end
  end

  task automatic wr_acc(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_acc(input logic [15:0] a, input logic [7:0] e, input bit e_err,
                        input string tag);
    rd_item_t it;
    @(negedge clk);
    addr = a; rd = 1'b1;
    it.a = a; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    rd = 1'b0;
    chk(derr == e_err, {tag, " err"}, derr, e_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({rdata, rvalid, le, light, sctl, map, srst, lock, derr} == '0, "R1 in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({rdata, rvalid, le, light, sctl, map, srst, lock, derr} == '0, "R1 after reset",
        {le, light, sctl, map}, 0);
    rd_acc(16'h0398, 8'h00, 1'b0, "R1 scratch0 reset");
    rd_acc(16'h0399, 8'h00, 1'b0, "R1 scratch1 reset");

    // R3 fixed codes, R2 read of 0x92
    rd_acc(16'h0800, 8'hEF, 1'b0, "R3 0x800");
    rd_acc(16'h0802, 8'hAD, 1'b0, "R3 0x802");
    rd_acc(16'h0803, 8'hE0, 1'b0, "R3 0x803");
    rd_acc(16'h080C, 8'h3C, 1'b0, "R3 0x80C");
    rd_acc(16'h0810, 8'h39, 1'b0, "R3 0x810");
    rd_acc(16'h0818, 8'h00, 1'b0, "R3 0x818");
    rd_acc(16'h0823, 8'h03, 1'b0, "R3 0x823");
    rd_acc(16'h0092, 8'h00, 1'b0, "R2 read 0x92");

    // R11 rvalid is a one-cycle pulse
    rd_acc(16'h0800, 8'hEF, 1'b0, "R11 data");
    chk(rvalid == 1'b1, "R11 rvalid high", rvalid, 1);
    @(negedge clk);
    chk(rvalid == 1'b0, "R11 rvalid drop", rvalid, 0);

    // R4 read-only writes
    wr_acc(16'h0800, 8'h12); chk(derr == 1'b0, "R4 no err 0x800", derr, 0);
    wr_acc(16'h0802, 8'h34); chk(derr == 1'b0, "R4 no err 0x802", derr, 0);
    wr_acc(16'h0803, 8'h56); chk(derr == 1'b0, "R4 no err 0x803", derr, 0);
    rd_acc(16'h0800, 8'hEF, 1'b0, "R4 0x800 kept");
    rd_acc(16'h0802, 8'hAD, 1'b0, "R4 0x802 kept");
    rd_acc(16'h0803, 8'hE0, 1'b0, "R4 0x803 kept");

    // R2 port 0x92
    wr_acc(16'h0092, 8'h03);
    chk(le == 1'b1, "R2 le set", le, 1);
    chk(srst == 1'b1, "R2 soft reset pulse", srst, 1);
    @(negedge clk);
    chk(srst == 1'b0, "R2 soft reset one cycle", srst, 0);
    wr_acc(16'h0092, 8'h00);
    chk(le == 1'b0 && srst == 1'b0, "R2 le clear no pulse", {le, srst}, 0);
    wr_acc(16'h0092, 8'hFE);
    chk(le == 1'b1 && srst == 1'b0, "R2 le only", {le, srst}, 2);

    // R5 disk lamp
    wr_acc(16'h0808, 8'h01); chk(light == 1'b1, "R5 light on", light, 1);
    wr_acc(16'h0808, 8'hFE); chk(light == 1'b0, "R5 light off", light, 0);
    wr_acc(16'h0808, 8'h81); chk(light == 1'b1, "R5 light on again", light, 1);

    // R6 lock toggles
    wr_acc(16'h0810, 8'h00); chk(lock == 2'b01, "R6 lock A pulse", lock, 1);
    @(negedge clk);          chk(lock == 2'b00, "R6 lock A drop", lock, 0);
    wr_acc(16'h0812, 8'hFF); chk(lock == 2'b10, "R6 lock B pulse", lock, 2);
    @(negedge clk);          chk(lock == 2'b00, "R6 lock B drop", lock, 0);

    // R7 system control field
    wr_acc(16'h081C, 8'hA5); chk(sctl == 4'h5, "R7 field masked", sctl, 5);
    rd_acc(16'h081C, 8'h05, 1'b0, "R7 readback 5");
    wr_acc(16'h081C, 8'h0F); chk(sctl == 4'hF, "R7 field F", sctl, 15);
    rd_acc(16'h081C, 8'h0F, 1'b0, "R7 readback F");

    // R8 map type
    wr_acc(16'h0850, 8'hFF); chk(map == 1'b1, "R8 map set", map, 1);
    rd_acc(16'h0850, 8'h01, 1'b0, "R8 readback 1");
    wr_acc(16'h0850, 8'h02); chk(map == 1'b0, "R8 map clear", map, 0);
    rd_acc(16'h0850, 8'h00, 1'b0, "R8 readback 0");

    // R10 scratch independence
    wr_acc(16'h0398, 8'h5A);
    wr_acc(16'h0399, 8'hC3);
    rd_acc(16'h0398, 8'h5A, 1'b0, "R10 scratch0");
    rd_acc(16'h0399, 8'hC3, 1'b0, "R10 scratch1");
    wr_acc(16'h0399, 8'h11);
    rd_acc(16'h0398, 8'h5A, 1'b0, "R10 scratch0 kept");
    rd_acc(16'h0399, 8'h11, 1'b0, "R10 scratch1 new");

    // R9 unlisted accesses; state now le=1 light=1 sctl=F map=0
    rd_acc(16'h0808, 8'hFF, 1'b1, "R9 read lamp addr");
    rd_acc(16'h0812, 8'hFF, 1'b1, "R9 read 0x812");
    rd_acc(16'h0851, 8'hFF, 1'b1, "R9 read 0x851");
    rd_acc(16'h0900, 8'hFF, 1'b1, "R9 read 0x900");
    rd_acc(16'h0814, 8'hFF, 1'b0, "R9 read 0x814");
    wr_acc(16'h0823, 8'h55); chk(derr == 1'b1, "R9 write 0x823 err", derr, 1);
    @(negedge clk);          chk(derr == 1'b0, "R9 err one cycle", derr, 0);
    wr_acc(16'h081D, 8'h00); chk(derr == 1'b1, "R9 write 0x81D err", derr, 1);
    wr_acc(16'h0093, 8'h01); chk(derr == 1'b1 && srst == 1'b0, "R9 write 0x93", {derr, srst}, 2);
    wr_acc(16'h039A, 8'h00); chk(derr == 1'b1, "R9 write 0x39A err", derr, 1);
    wr_acc(16'h0814, 8'h00); chk(derr == 1'b0, "R9 write 0x814 ok", derr, 0);
    chk({le, light, sctl, map} == 7'b11_1111_0, "R9 latches unchanged",
        {le, light, sctl, map}, 7'b1111110);
    rd_acc(16'h0823, 8'h03, 1'b0, "R9 0x823 unchanged");
    rd_acc(16'h0398, 8'h5A, 1'b0, "R9 scratch0 unchanged");
    rd_acc(16'h0399, 8'h11, 1'b0, "R9 scratch1 unchanged");

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all reads returned", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule